// File: doc/BRIEF.md
# Synchronous Bus Read Cycle Controller

This block runs a single read transfer on a shared parallel bus on behalf of one master. The transfer has a fixed length. The controller waits in idle until the master pulls its active-low request down. It then walks through five further phases, one per clock edge, and returns to idle. The phases are: bus granted, address presented, read strobe issued, data captured and bus released. No acknowledge comes back from the slave, so the slave must have its data on the bus by the end of the capture phase.

Every control strobe is active low. The four strobes, read, address-valid, chip-select and grant, follow a fixed pattern in each phase, so that downstream logic can decode the phase from them. The address is latched from the master at the end of the grant phase. It is driven onto the bus only while the slave may use it and is zero at all other times. The returned data is registered and held for the master until the next transfer replaces it.

Top module: `sbus_read_ctrl`

## Requirements
- R1: A synchronous active-high reset forces phase 0. It drives all four strobes high, the release flag low, the address output to zero and the captured data to zero.
- R2: In phase 0 all four strobes are high. While the request input is high, the controller stays in phase 0.
- R3: When the request is sampled low in phase 0, the next phase is 1. In phase 1 only the grant strobe is low, giving the packed value {read, addr-valid, chip-select, grant} = 4'hE.
- R4: In phase 2, chip-select and address-valid go low along with grant, giving the packed value 4'h8.
- R5: In phases 3, 4 and 5 all four strobes are low, giving the packed value 4'h0.
- R6: The data input is sampled at the clock edge that ends phase 4. It appears on the data output in phase 5 and is held until the next such edge or a reset.
- R7: The release flag is high in phase 5 and only there. The edge after phase 5 always returns to phase 0.
- R8: The address input is latched at the edge that ends phase 1. It is driven on the address output during phases 2 to 4 and is zero in all other phases.
- R9: Phases 1 to 4 each advance to the next phase on every clock. The request input is ignored in all phases except phase 0.
- R10: The phase output carries the current phase as a 3-bit binary number from 0 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Bus request from the master, active low |
| mst_addr | input | ADDR_W | Address the master wants to read |
| bus_din | input | DATA_W | Data driven by the slave |
| grant_n | output | 1 | Bus grant, active low |
| cs_n | output | 1 | Slave chip-select, active low |
| avld_n | output | 1 | Address-valid strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Address driven to the slave, zero outside phases 2 to 4 |
| rd_data | output | DATA_W | Data captured from the slave |
| release_o | output | 1 | Bus release indication, high in phase 5 |
| phase_o | output | 3 | Current phase, 0 to 5 |

## Verification
The assertions assume that reset is held for at least one clock before anything is checked. They also assume that the slave's data is valid on the edge that closes phase 4, because no handshake exists to say otherwise. The stimulus asserts reset at the start and once in the middle of a transfer. It changes the address and data inputs on every cycle, so that only the sampling edges decide what is captured. It also toggles the request during busy phases and holds it low across consecutive transfers. This shows that the request matters only in idle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GRANT = 3'd1,
    PH_ADDR  = 3'd2,
    PH_READ  = 3'd3,
    PH_CAPT  = 3'd4,
    PH_DONE  = 3'd5
  } phase_t;

  // Packed strobe vector {rd_n, avld_n, cs_n, grant_n} for a phase.
  function automatic logic [3:0] strobes_for(input phase_t ph);
    logic [3:0] s;
    s = 4'hF;
    if (ph != PH_IDLE)                      s[0] = 1'b0;
    if (ph != PH_IDLE && ph != PH_GRANT)    s[2:1] = 2'b00;
    if (ph == PH_READ || ph == PH_CAPT || ph == PH_DONE) s[3] = 1'b0;
    return s;
  endfunction

  // True in phases where the slave may use the address.
  function automatic logic addr_window(input phase_t ph);
    return (ph == PH_ADDR) || (ph == PH_READ) || (ph == PH_CAPT);
  endfunction

  // Successor of a busy phase.
  function automatic phase_t next_busy(input phase_t ph);
    phase_t n;
    case (ph)
      PH_GRANT: n = PH_ADDR;
      PH_ADDR:  n = PH_READ;
      PH_READ:  n = PH_CAPT;
      PH_CAPT:  n = PH_DONE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sbus_phase_seq.sv
module sbus_phase_seq
  import sbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_n,
  output phase_t phase,
  output logic   start_evt,
  output logic   latch_evt,
  output logic   cap_evt
);

  phase_t phase_q, phase_d;

  assign start_evt = (phase_q == PH_IDLE) && !req_n;
  assign latch_evt = (phase_q == PH_GRANT);
  assign cap_evt   = (phase_q == PH_CAPT);

  always_comb begin
    if (phase_q == PH_IDLE) phase_d = start_evt ? PH_GRANT : PH_IDLE;
    else                    phase_d = next_busy(phase_q);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/sbus_addr_hold.sv
module sbus_addr_hold
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_evt,
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] mst_addr,
  output logic [ADDR_W-1:0] bus_addr
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)            addr_q <= '0;
    else if (latch_evt) addr_q <= mst_addr;
  end

  assign bus_addr = addr_window(phase) ? addr_q : '0;

endmodule

// File: rtl/sbus_capture.sv
module sbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (cap_evt) rd_data <= bus_din;
  end

endmodule

// File: rtl/sbus_read_ctrl.sv
module sbus_read_ctrl
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_n,
  input  logic [ADDR_W-1:0] mst_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              grant_n,
  output logic              cs_n,
  output logic              avld_n,
  output logic              rd_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              release_o,
  output logic [2:0]        phase_o
);

  phase_t     phase;
  logic       start_evt;
  logic       latch_evt;
  logic       cap_evt;
  logic [3:0] strobes;

  sbus_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_n     (req_n),
    .phase     (phase),
    .start_evt (start_evt),
    .latch_evt (latch_evt),
    .cap_evt   (cap_evt)
  );

  sbus_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .latch_evt (latch_evt),
    .phase     (phase),
    .mst_addr  (mst_addr),
    .bus_addr  (bus_addr)
  );

  sbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap_evt (cap_evt),
    .bus_din (bus_din),
    .rd_data (rd_data)
  );

  assign strobes   = strobes_for(phase);
  assign rd_n      = strobes[3];
  assign avld_n    = strobes[2];
  assign cs_n      = strobes[1];
  assign grant_n   = strobes[0];
  assign release_o = (phase == PH_DONE);
  assign phase_o   = phase;

endmodule

// File: rtl/sbus_read_chk.sv
module sbus_read_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_n,
  input logic [DATA_W-1:0] bus_din,
  input logic              grant_n,
  input logic              cs_n,
  input logic              avld_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              release_o,
  input logic [2:0]        phase_o,
  input logic              start_evt
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == 3'd0 && rd_data == '0 && !release_o));

  // R2
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd0) |-> ({rd_n, avld_n, cs_n, grant_n} == 4'hF));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd0 && req_n) |=> (phase_o == 3'd0));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (phase_o == 3'd1 && !grant_n && cs_n));

  // R5
  all_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o >= 3'd3 && phase_o <= 3'd5) |-> ({rd_n, avld_n, cs_n, grant_n} == 4'h0));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd5) |-> (rd_data == $past(bus_din)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    release_o |=> (phase_o == 3'd0));

  // R8
  addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o < 3'd2 || phase_o > 3'd4) |-> (bus_addr == '0));

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 || phase_o == 3'd4) |-> $stable(bus_addr));

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o >= 3'd1 && phase_o <= 3'd4) |=> (phase_o == $past(phase_o) + 3'd1));

  // R10
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_o <= 3'd5);

endmodule

bind sbus_read_ctrl sbus_read_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_n     (req_n),
  .bus_din   (bus_din),
  .grant_n   (grant_n),
  .cs_n      (cs_n),
  .avld_n    (avld_n),
  .rd_n      (rd_n),
  .bus_addr  (bus_addr),
  .rd_data   (rd_data),
  .release_o (release_o),
  .phase_o   (phase_o),
  .start_evt (start_evt)
);

// File: tb/sbus_read_ctrl_bench.sv
`timescale 1ns/100ps
module sbus_read_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_n = 1'b1;
  logic [AW-1:0] mst_addr = '0;
  logic [DW-1:0] bus_din = '0;
  logic          grant_n, cs_n, avld_n, rd_n, release_o;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] rd_data;
  logic [2:0]    phase_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sbus_read_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_sbus_read_ctrl (
    .clk(clk), .rst(rst), .req_n(req_n), .mst_addr(mst_addr), .bus_din(bus_din),
    .grant_n(grant_n), .cs_n(cs_n), .avld_n(avld_n), .rd_n(rd_n),
    .bus_addr(bus_addr), .rd_data(rd_data), .release_o(release_o), .phase_o(phase_o)
  );

  // Behavioural reference: phase counter, held address, held data.
  int     m_ph = 0;
  int     m_addr = 0;
  int     m_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_addr = 0; m_data = 0;
    end else if (m_ph == 0) begin
      if (req_n == 1'b0) m_ph = 1;
    end else begin
      if (m_ph == 1) m_addr = int'(mst_addr);
      if (m_ph == 4) m_data = int'(bus_din);
      m_ph = (m_ph == 5) ? 0 : m_ph + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_strobes(input int ph);
    if (ph == 0) return 'hF;
    if (ph == 1) return 'hE;
    if (ph == 2) return 'h8;
    return 'h0;
  endfunction

  function automatic string strobe_tag(input int ph);
    if (ph == 0) return "R2 strobes";
    if (ph == 1) return "R3 strobes";
    if (ph == 2) return "R4 strobes";
    return "R5 strobes";
  endfunction

  bit compare_on = 1'b0;

  always @(negedge clk) begin
    if (compare_on && !done) begin
      check((m_ph == 0) ? "R10 phase" : "R9 phase", int'(phase_o), m_ph);
      check(strobe_tag(m_ph), int'({rd_n, avld_n, cs_n, grant_n}), exp_strobes(m_ph));
      check("R7 release", int'(release_o), (m_ph == 5) ? 1 : 0);
      check("R8 address", int'(bus_addr), (m_ph >= 2 && m_ph <= 4) ? m_addr : 0);
      check("R6 data", int'(rd_data), m_data);
    end
  end

  task automatic step(input logic rq);
    @(negedge clk);
    #0.5;
    req_n    = rq;
    mst_addr = AW'($urandom);
    bus_din  = DW'($urandom);
  endtask

  task automatic transfer(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #0.5;
    req_n = 1'b0;
    // idle -> 1
    @(negedge clk); #0.5;
    req_n = 1'b1; mst_addr = a;            // phase 1: address sampled at its end
    @(negedge clk); #0.5; mst_addr = ~a;   // phase 2
    @(negedge clk); #0.5; req_n = 1'b0;    // phase 3, request ignored
    @(negedge clk); #0.5; bus_din = d;     // phase 4: data sampled at its end
    @(negedge clk); #0.5; bus_din = ~d; req_n = 1'b1; // phase 5
    @(negedge clk); #0.5;                   // back in idle
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 phase", int'(phase_o), 0);
    check("R1 strobes", int'({rd_n, avld_n, cs_n, grant_n}), 'hF);
    check("R1 data", int'(rd_data), 0);
    check("R1 address", int'(bus_addr), 0);
    check("R1 release", int'(release_o), 0);
    compare_on = 1'b1;
    // R2: idle with request high
    for (int i = 0; i < 6; i++) step(1'b1);
    transfer(8'hA5, 8'h3C);
    transfer(8'h00, 8'hFF);
    transfer(8'hFF, 8'h00);
    // R9: request held low, back-to-back transfers, random other inputs
    for (int i = 0; i < 20; i++) step(1'b0);
    // random request pattern
    for (int i = 0; i < 200; i++) step(1'($urandom));
    // reset in the middle of a transfer (R1)
    step(1'b0); step(1'b1); step(1'b1);
    #0.5 rst = 1'b1;
    step(1'b0); step(1'b0);
    #0.5 rst = 1'b0;
    for (int i = 0; i < 40; i++) step(1'($urandom));
    step(1'b1);
    for (int i = 0; i < 8; i++) step(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule